// File: doc/BRIEF.md
# Two-Phase to Alpha/Beta Fixed-Point Converter

This block maps a pair of signed phase samples from a balanced three-phase system onto the stationary alpha/beta frame. The three phases are assumed to sum to zero, so the third phase is never an input. Alpha is phase A passed through unchanged. Beta is (A + 2B) scaled by one over root three.

The scaling uses a fixed-point constant multiply. The sum A + 2B is formed with two guard bits, so it never wraps. The product is rounded half-up to the output width and then clipped to the signed range. A qualifier strobe travels beside the data. Alpha, beta and the strobe come out together after a fixed two-clock latency. While no sample is in flight, the result registers keep their last loaded values.

Top module: `clarke_fwd_unit`

## Requirements
- R1: While reset (active high) is asserted, outValid, alphaOut and betaOut are all zero at every rising edge.
- R2: outValid is high in the cycle exactly two rising edges after inValid was sampled high, and low otherwise.
- R3: When outValid is high, alphaOut equals the phaseA value that was sampled together with that strobe, bit for bit.
- R4: When outValid is high, betaOut equals floor((S * 75674 + 65536) / 131072), where S = A + 2B is computed without wrapping. 75674 is 1/√3 rounded to 17 fractional bits. The formula rounds to nearest, with ties going toward positive infinity.
- R5: A beta result above 2^(W-1)-1 is replaced by 2^(W-1)-1. A result that equals this limit is not changed.
- R6: A beta result below -2^(W-1) is replaced by -2^(W-1). A result that equals this limit is not changed.
- R7: Full-scale inputs never wrap: the sign of betaOut always agrees with the sign of A + 2B, including for A = B = the most positive or the most negative code.
- R8: When no valid sample reaches the output stage, alphaOut and betaOut keep their previous values. Phase inputs presented while inValid is low have no effect on them.
- R9: Samples presented on consecutive cycles produce results on consecutive cycles, in the same order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Qualifies phaseA and phaseB this cycle |
| phaseA | input | DATA_W | Signed phase A sample |
| phaseB | input | DATA_W | Signed phase B sample |
| outValid | output | 1 | Qualifies alphaOut and betaOut |
| alphaOut | output | DATA_W | Signed alpha component |
| betaOut | output | DATA_W | Signed beta component |

## Verification
The bench targets each saturation threshold from both sides. On the positive side it applies a sum that rounds to exactly the limit and one that rounds to one code past it. On the negative side it applies a sum that lands exactly on the limit and one that lands one code below it. A design with a wrong compare bound would clip a legal value or let an overflow through. Full-scale inputs of equal sign check the guard bits: a design that is too narrow would return a beta of the wrong sign. Small negative sums expose truncation toward zero where rounding is required, because they would come out one code too high. Idle cycles with changing inputs and an isolated strobe expose output registers that load without qualification, or a valid path whose delay differs from the data path.

// File: rtl/clarke_pkg.sv
package clarke_pkg;

  // Load strobes issued by the control to the datapath stages
  typedef struct packed {
    logic ldSum;    // capture A + 2B and phase A into stage 1
    logic ldOut;    // capture scaled beta and alpha into stage 2
  } ctrlStrobes_t;

  // Round-to-nearest of 2^frac / sqrt(3), computed by integer square root
  function automatic longint unsigned recipRoot3(input int frac);
    longint unsigned target;
    longint unsigned lo;
    longint unsigned hi;
    longint unsigned mid;
    target = (64'd1 << (2 * frac + 2)) / 64'd3;
    lo = 0;
    hi = 64'd1 << (frac + 1);
    while (lo < hi) begin
      mid = (lo + hi + 1) >> 1;
      if (mid * mid <= target) lo = mid;
      else hi = mid - 1;
    end
    return (lo + 1) >> 1;
  endfunction

endpackage

// File: rtl/clarke_ctrl.sv
module clarke_ctrl
  import clarke_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output ctrlStrobes_t strobes,
  output logic         outValid
);

  localparam int STAGES = 2;

  logic [STAGES-1:0] validPipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      validPipe <= '0;
    end else begin
      validPipe <= {validPipe[STAGES-2:0], inValid};
    end
  end

  always_comb begin
    strobes.ldSum = inValid;
    strobes.ldOut = validPipe[0];
  end

  assign outValid = validPipe[STAGES-1];

  // R2: strobe leaves exactly two edges after it entered
  p_valid_latency_r2: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid, 2));

  p_valid_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (!inValid && !validPipe[0]) |=> ##1 !outValid);

endmodule

// File: rtl/clarke_scale_sat.sv
module clarke_scale_sat #(
  parameter int DATA_W    = 16,
  parameter int SUM_W     = DATA_W + 2,
  parameter int COEF_FRAC = 17,
  parameter int COEF_W    = COEF_FRAC + 1
) (
  input  logic signed [SUM_W-1:0]  sumIn,
  output logic signed [DATA_W-1:0] betaNext
);

  localparam int PROD_W = SUM_W + COEF_W + 1;
  localparam logic [COEF_W-1:0] COEF_VAL =
    COEF_W'(clarke_pkg::recipRoot3(COEF_FRAC));
  localparam logic signed [PROD_W-1:0] HALF_LSB =
    PROD_W'(64'd1 << (COEF_FRAC - 1));
  localparam logic signed [PROD_W-1:0] MAX_V =
    {{(PROD_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [PROD_W-1:0] MIN_V =
    {{(PROD_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [PROD_W-1:0] sumExt;
  logic signed [PROD_W-1:0] coefExt;
  logic signed [PROD_W-1:0] product;
  logic signed [PROD_W-1:0] rounded;
  logic signed [PROD_W-1:0] shifted;

  always_comb begin
    sumExt  = {{(PROD_W-SUM_W){sumIn[SUM_W-1]}}, sumIn};
    coefExt = {{(PROD_W-COEF_W){1'b0}}, COEF_VAL};
    product = sumExt * coefExt;
    rounded = product + HALF_LSB;
    shifted = rounded >>> COEF_FRAC;
    if (shifted > MAX_V) begin
      betaNext = MAX_V[DATA_W-1:0];
    end else if (shifted < MIN_V) begin
      betaNext = MIN_V[DATA_W-1:0];
    end else begin
      betaNext = shifted[DATA_W-1:0];
    end
  end

endmodule

// File: rtl/clarke_datapath.sv
module clarke_datapath
  import clarke_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_FRAC = 17
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ctrlStrobes_t             strobes,
  input  logic signed [DATA_W-1:0] phaseA,
  input  logic signed [DATA_W-1:0] phaseB,
  output logic signed [DATA_W-1:0] alphaOut,
  output logic signed [DATA_W-1:0] betaOut
);

  localparam int SUM_W = DATA_W + 2;
  localparam logic signed [SUM_W-1:0] SUM_TOP =
    SUM_W'(3 * ((64'd1 << (DATA_W - 1)) - 1));
  localparam logic signed [DATA_W-1:0] OUT_TOP = {1'b0, {(DATA_W-1){1'b1}}};

  logic signed [SUM_W-1:0]  sumNext;
  logic signed [SUM_W-1:0]  sumReg;
  logic signed [DATA_W-1:0] alphaReg;
  logic signed [DATA_W-1:0] betaNext;

  // Guard bits keep A + 2B inside range for every input pair
  always_comb begin
    sumNext = {{2{phaseA[DATA_W-1]}}, phaseA}
            + {phaseB[DATA_W-1], phaseB, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sumReg   <= '0;
      alphaReg <= '0;
    end else if (strobes.ldSum) begin
      sumReg   <= sumNext;
      alphaReg <= phaseA;
    end
  end

  clarke_scale_sat #(
    .DATA_W    (DATA_W),
    .SUM_W     (SUM_W),
    .COEF_FRAC (COEF_FRAC)
  ) scale_i (
    .sumIn    (sumReg),
    .betaNext (betaNext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      alphaOut <= '0;
      betaOut  <= '0;
    end else if (strobes.ldOut) begin
      alphaOut <= alphaReg;
      betaOut  <= betaNext;
    end
  end

  // R8: result registers keep their value without a load strobe
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !strobes.ldOut |=> ($stable(betaOut) && $stable(alphaOut)));

  // R7: sign of beta follows the sign of the guarded sum
  p_sign_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (strobes.ldOut && !sumReg[SUM_W-1]) |=> !betaOut[DATA_W-1]);

  p_neg_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (strobes.ldOut && sumReg[SUM_W-1]) |=> betaOut[DATA_W-1]);

  // R5: the largest sum pins beta at the top code
  p_sat_top_r5: assert property (@(posedge clk) disable iff (rst)
    (strobes.ldOut && sumReg == SUM_TOP) |=> betaOut == OUT_TOP);

endmodule

// File: rtl/clarke_fwd_unit.sv
module clarke_fwd_unit #(
  parameter int DATA_W    = 16,
  parameter int COEF_FRAC = 17
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] phaseA,
  input  logic signed [DATA_W-1:0] phaseB,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] alphaOut,
  output logic signed [DATA_W-1:0] betaOut
);

  import clarke_pkg::*;

  ctrlStrobes_t strobes;

  clarke_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  clarke_datapath #(
    .DATA_W    (DATA_W),
    .COEF_FRAC (COEF_FRAC)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .phaseA   (phaseA),
    .phaseB   (phaseB),
    .alphaOut (alphaOut),
    .betaOut  (betaOut)
  );

  // R1: reset clears every output
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!outValid && alphaOut == '0 && betaOut == '0));

  // R3: alpha is phase A delayed by the pipeline, unchanged
  p_alpha_pass_r3: assert property (@(posedge clk) disable iff (rst)
    outValid |-> alphaOut == $past(phaseA, 2));

endmodule

// File: tb/clarke_fwd_unit_tb_top.sv
module clarke_fwd_unit_tb_top;

  localparam int W = 16;
  localparam int NV = 15;

  localparam int VA[NV] = '{0, 1, -1, 100, -100, 1000, 10000, 20000,
                            20000, 20000, -20000, -20000, 32767, -32768, 32767};
  localparam int VB[NV] = '{0, 0, 0, 50, -50, -500, 5000, 10000,
                            18377, 18378, -18378, -18379, 32767, -32768, -32768};
  localparam int VE[NV] = '{0, 1, -1, 115, -115, 0, 11547, 23094,
                            32767, 32767, -32768, -32768, 32767, -32768, -18919};
  localparam string VR[NV] = '{"R4", "R4", "R4", "R4", "R4", "R4", "R4", "R4",
                               "R5", "R5", "R6", "R6", "R7", "R7", "R4"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic signed [W-1:0] phaseA = '0;
  logic signed [W-1:0] phaseB = '0;
  logic outValid;
  logic signed [W-1:0] alphaOut;
  logic signed [W-1:0] betaOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clarke_fwd_unit #(.DATA_W(W), .COEF_FRAC(17)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .phaseA   (phaseA),
    .phaseB   (phaseB),
    .outValid (outValid),
    .alphaOut (alphaOut),
    .betaOut  (betaOut)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) tick();
    // R1: outputs cleared while reset held
    chk("R1", "outValid in reset", int'(outValid), 0);
    chk("R1", "alpha in reset", int'(alphaOut), 0);
    chk("R1", "beta in reset", int'(betaOut), 0);
    rst = 1'b0;
    tick();

    // R9: table streamed back to back, checked two cycles later
    for (int i = 0; i < NV + 2; i++) begin
      if (i >= 2) begin
        chk("R9", "outValid streaming", int'(outValid), 1);
        chk("R3", "alpha", int'(alphaOut), VA[i-2]);
        chk(VR[i-2], $sformatf("beta vec %0d", i - 2), int'(betaOut), VE[i-2]);
      end
      if (i < NV) begin
        inValid = 1'b1;
        phaseA = W'(VA[i]);
        phaseB = W'(VB[i]);
      end else begin
        inValid = 1'b0;
        phaseA = 16'sd1234;
        phaseB = -16'sd4321;
      end
      tick();
    end

    // R8: idle inputs changing, outputs hold last result
    for (int k = 0; k < 4; k++) begin
      phaseA = W'(k * 977 - 3000);
      phaseB = W'(5000 - k * 311);
      tick();
      chk("R2", "outValid idle", int'(outValid), 0);
      chk("R8", "alpha hold", int'(alphaOut), VA[NV-1]);
      chk("R8", "beta hold", int'(betaOut), VE[NV-1]);
    end

    // R2: isolated strobe, latency of exactly two edges
    inValid = 1'b1;
    phaseA = -16'sd300;
    phaseB = 16'sd75;
    tick();
    inValid = 1'b0;
    phaseA = 16'sd9;
    chk("R2", "outValid after one edge", int'(outValid), 0);
    tick();
    chk("R2", "outValid after two edges", int'(outValid), 1);
    chk("R3", "alpha isolated", int'(alphaOut), -300);
    // S = -150: (-150*75674+65536)/131072 floor = -87
    chk("R4", "beta isolated", int'(betaOut), -87);
    tick();
    chk("R2", "outValid pulse ends", int'(outValid), 0);

    // R1: reset in the middle of traffic clears outputs
    inValid = 1'b1;
    phaseA = 16'sd500;
    phaseB = 16'sd500;
    tick();
    rst = 1'b1;
    tick();
    chk("R1", "outValid mid reset", int'(outValid), 0);
    chk("R1", "alpha mid reset", int'(alphaOut), 0);
    chk("R1", "beta mid reset", int'(betaOut), 0);
    inValid = 1'b0;
    rst = 1'b0;
    tick();
    tick();
    chk("R1", "no stale valid after reset", int'(outValid), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule